// File: doc/BRIEF.md
# Timer Interrupt Routing Unit

This block sits between a bank of N timer channels and the interrupt fabric of a chip. Each channel presents a one-cycle fire pulse. The block turns that pulse into one of three outputs, chosen by the channel's configuration. A level-mode channel latches a status bit and holds one of 32 interrupt lines high. An edge-mode channel pulses that line for one cycle. A message-mode channel sends a single 32-bit address/data write.

Software clears a latched status bit by writing a one to it. A global legacy mode pins channel 0 to line 0 and channel 1 to line 8. Legacy mode also mutes an external real-time-clock interrupt input, which otherwise reaches line 8 directly.

The counters, comparators and register decode live elsewhere. This block receives their configuration as plain input vectors. Every output is registered, so the effect of a fire pulse sampled at a clock edge is visible just after that edge.

Top module: `tirq_router`

## Requirements
- R1: Each channel drives the line given by its own 5-bit route field. When legacy_i is 1, channel 0 drives line 0 and channel 1 drives line 8, whatever their route fields hold.
- R2: A fire on an enabled channel with level_i=1 and msg_en_i=0 sets its status bit and raises its line after the same clock edge. The bit and the line then hold until cleared. With level_i=0 the line is high for exactly one cycle and no status bit is set.
- R3: While a channel's tmr_en_i bit or glb_en_i is 0, its status bit is cleared after the next edge and its fires have no effect on lines, status or messages.
- R4: When clr_we_i is 1, a 1 in clr_data_i bit i clears status bit i and lowers its line, and a 0 leaves it unchanged. A fire in the same cycle as the clear wins.
- R5: A fire on an enabled channel with msg_en_i=1 produces exactly one message write, two edges after the fire. The address is bits 63:32 of the channel's 64-bit message register and the data is bits 31:0. No status bit or line is touched.
- R6: Pending message writes go out one per cycle, lowest channel index first. A channel that fires again while its write is still pending yields only one write.
- R7: A 0-to-1 change of a channel's msg_en_i bit clears that channel's status bit.
- R8: Outside legacy mode, line 8 follows rtc_i one edge later. Entering legacy mode lowers the RTC contribution. Leaving legacy mode drives line 8 to the current rtc_i level again.
- R9: A line is high while any non-message channel routed to it has its status bit set, or an edge pulse targets it. Several channels can share one line.
- R10: After reset all status bits are 0, all lines are low and no message write is issued or pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| glb_en_i | input | 1 | Global interrupt enable |
| legacy_i | input | 1 | Legacy fixed routing mode |
| tmr_en_i | input | N | Per-channel interrupt enable |
| level_i | input | N | 1 = level signalling, 0 = edge pulse |
| msg_en_i | input | N | Per-channel message-write routing |
| route_i | input | N*5 | Per-channel line number, channel i at bits 5i+4:5i |
| msg_reg_i | input | N*64 | Per-channel message register, channel i at bits 64i+63:64i |
| fire_i | input | N | One-cycle fire pulse per channel |
| clr_we_i | input | 1 | Status write-one-to-clear strobe |
| clr_data_i | input | N | Clear mask |
| rtc_i | input | 1 | External RTC interrupt level |
| irq_o | output | 32 | Interrupt lines |
| status_o | output | N | Latched level-mode status bits |
| msg_valid_o | output | 1 | Message write strobe |
| msg_addr_o | output | 32 | Message write address |
| msg_data_o | output | 32 | Message write data |

## Verification
A wrong status bit shows on status_o and on the routed line one cycle after the offending edge. A line is also wrong at once if it fails to drop after a clear, or if another channel sharing it drops it too early.

A faulty pending set or arbiter shows up as writes that are missing, duplicated or out of order. These appear two or more cycles after the fires that queued them, so the bench compares every cycle against its model.

A misplaced legacy or RTC gate shows on lines 0 and 8 one cycle after legacy_i or rtc_i changes.

// File: rtl/tirq_pkg.sv
package tirq_pkg;
  localparam int unsigned LINE_LEG0 = 0;
  localparam int unsigned LINE_LEG1 = 8;
  localparam int unsigned LINE_RTC  = 8;
  localparam int unsigned MSG_W     = 64;
  localparam int unsigned HALF_W    = 32;

  typedef struct packed {
    logic [HALF_W-1:0] addr;
    logic [HALF_W-1:0] data;
  } msg_t;
endpackage

// File: rtl/tirq_status.sv
module tirq_status #(
  parameter int unsigned N = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         glb_en_i,
  input  logic [N-1:0] tmr_en_i,
  input  logic [N-1:0] level_i,
  input  logic [N-1:0] msg_en_i,
  input  logic [N-1:0] fire_i,
  input  logic         clr_we_i,
  input  logic [N-1:0] clr_data_i,
  output logic [N-1:0] status_q,
  output logic [N-1:0] status_d,
  output logic [N-1:0] edge_fire,
  output logic [N-1:0] msg_fire
);
  logic [N-1:0] men_q;
  logic [N-1:0] live;
  logic [N-1:0] set_lvl;
  logic [N-1:0] kill;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_ch
      assign live[g]      = fire_i[g] & tmr_en_i[g] & glb_en_i;
      assign set_lvl[g]   = live[g] & level_i[g] & ~msg_en_i[g];
      assign edge_fire[g] = live[g] & ~level_i[g] & ~msg_en_i[g];
      assign msg_fire[g]  = live[g] & msg_en_i[g];
      assign kill[g]      = (clr_we_i & clr_data_i[g]) | ~tmr_en_i[g] | ~glb_en_i
                          | (msg_en_i[g] & ~men_q[g]);
      assign status_d[g]  = set_lvl[g] | (status_q[g] & ~kill[g]);

      always_ff @(posedge clk) begin
        if (rst) begin
          status_q[g] <= 1'b0;
          men_q[g]    <= 1'b0;
        end else begin
          status_q[g] <= status_d[g];
          men_q[g]    <= msg_en_i[g];
        end
      end

      // R4: a one written to a set bit clears it unless it fires again
      p_w1c_r4: assert property (@(posedge clk) disable iff (rst)
        (clr_we_i && clr_data_i[g] && !fire_i[g]) |=> !status_q[g]);
      // R7: message enable rising clears status
      p_msg_rise_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(msg_en_i[g]) |=> !status_q[g]);
      // R3: a disabled channel holds no status
      p_disabled_r3: assert property (@(posedge clk) disable iff (rst)
        (!tmr_en_i[g] || !glb_en_i) |=> !status_q[g]);
    end
  endgenerate
endmodule

// File: rtl/tirq_linemap.sv
module tirq_linemap
  import tirq_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned NLINES = 32,
  parameter int unsigned RW     = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              legacy_i,
  input  logic              rtc_i,
  input  logic [N*RW-1:0]   route_i,
  input  logic [N-1:0]      msg_en_i,
  input  logic [N-1:0]      status_d,
  input  logic [N-1:0]      edge_fire,
  output logic [NLINES-1:0] irq_q
);
  logic [RW-1:0]     eff [N];
  logic [N-1:0]      drive;
  logic [NLINES-1:0] lines_d;

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_eff
      if (g == 0) begin : g_l0
        assign eff[g] = legacy_i ? RW'(LINE_LEG0) : route_i[g*RW +: RW];
      end else if (g == 1) begin : g_l1
        assign eff[g] = legacy_i ? RW'(LINE_LEG1) : route_i[g*RW +: RW];
      end else begin : g_ln
        assign eff[g] = route_i[g*RW +: RW];
      end
      assign drive[g] = (status_d[g] & ~msg_en_i[g]) | edge_fire[g];
    end
  endgenerate

  always_comb begin
    lines_d = '0;
    for (int i = 0; i < N; i++) begin
      if (drive[i]) lines_d[eff[i]] = 1'b1;
    end
    if (!legacy_i && rtc_i) lines_d[LINE_RTC] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_q <= '0;
    else     irq_q <= lines_d;
  end

  // R9: an undriven line with no RTC source is low after the edge
  p_idle_low_r9: assert property (@(posedge clk) disable iff (rst)
    (drive == '0 && (legacy_i || !rtc_i)) |=> (irq_q == '0));
endmodule

// File: rtl/tirq_msgq.sv
module tirq_msgq
  import tirq_pkg::*;
#(
  parameter int unsigned N  = 8,
  parameter int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N-1:0]     msg_fire,
  input  logic [N*MSG_W-1:0] msg_reg_i,
  output logic             msg_valid_q,
  output msg_t             msg_q
);
  logic [N-1:0]  pend_q;
  logic [N-1:0]  pend_d;
  logic [N-1:0]  grant;
  logic [IW-1:0] sel;
  logic          found;
  logic [MSG_W-1:0] mreg [N];

  genvar g;
  generate
    for (g = 0; g < N; g++) begin : g_m
      assign mreg[g] = msg_reg_i[g*MSG_W +: MSG_W];
    end
  endgenerate

  always_comb begin
    sel   = '0;
    found = 1'b0;
    grant = '0;
    for (int i = 0; i < N; i++) begin
      if (pend_q[i] && !found) begin
        sel      = IW'(i);
        found    = 1'b1;
        grant[i] = 1'b1;
      end
    end
    pend_d = (pend_q & ~grant) | msg_fire;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q      <= '0;
      msg_valid_q <= 1'b0;
      msg_q       <= '0;
    end else begin
      pend_q      <= pend_d;
      msg_valid_q <= found;
      if (found) begin
        msg_q.addr <= mreg[sel][MSG_W-1:HALF_W];
        msg_q.data <= mreg[sel][HALF_W-1:0];
      end
    end
  end

  // R5: a write only follows a pending request
  p_write_src_r5: assert property (@(posedge clk) disable iff (rst)
    msg_valid_q |-> ($past(pend_q) != '0));
  // R6: one grant per cycle drains one pending bit
  p_one_grant_r6: assert property (@(posedge clk) disable iff (rst)
    (msg_fire == '0 && pend_q != '0) |=> ($countones(pend_q) == $countones($past(pend_q)) - 1));
endmodule

// File: rtl/tirq_router.sv
module tirq_router
  import tirq_pkg::*;
#(
  parameter int unsigned N      = 8,
  parameter int unsigned NLINES = 32,
  parameter int unsigned RW     = $clog2(NLINES)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 glb_en_i,
  input  logic                 legacy_i,
  input  logic [N-1:0]         tmr_en_i,
  input  logic [N-1:0]         level_i,
  input  logic [N-1:0]         msg_en_i,
  input  logic [N*RW-1:0]      route_i,
  input  logic [N*MSG_W-1:0]   msg_reg_i,
  input  logic [N-1:0]         fire_i,
  input  logic                 clr_we_i,
  input  logic [N-1:0]         clr_data_i,
  input  logic                 rtc_i,
  output logic [NLINES-1:0]    irq_o,
  output logic [N-1:0]         status_o,
  output logic                 msg_valid_o,
  output logic [HALF_W-1:0]    msg_addr_o,
  output logic [HALF_W-1:0]    msg_data_o
);
  logic [N-1:0] status_d;
  logic [N-1:0] edge_fire;
  logic [N-1:0] msg_fire;
  msg_t         msg;
  logic         rst_q;

  tirq_status #(.N(N)) u_status (
    .clk(clk), .rst(rst), .glb_en_i(glb_en_i), .tmr_en_i(tmr_en_i),
    .level_i(level_i), .msg_en_i(msg_en_i), .fire_i(fire_i),
    .clr_we_i(clr_we_i), .clr_data_i(clr_data_i),
    .status_q(status_o), .status_d(status_d),
    .edge_fire(edge_fire), .msg_fire(msg_fire)
  );

  tirq_linemap #(.N(N), .NLINES(NLINES), .RW(RW)) u_lines (
    .clk(clk), .rst(rst), .legacy_i(legacy_i), .rtc_i(rtc_i),
    .route_i(route_i), .msg_en_i(msg_en_i), .status_d(status_d),
    .edge_fire(edge_fire), .irq_q(irq_o)
  );

  tirq_msgq #(.N(N)) u_msg (
    .clk(clk), .rst(rst), .msg_fire(msg_fire), .msg_reg_i(msg_reg_i),
    .msg_valid_q(msg_valid_o), .msg_q(msg)
  );

  assign msg_addr_o = msg.addr;
  assign msg_data_o = msg.data;

  always_ff @(posedge clk) rst_q <= rst;

  // R10: outputs idle one edge after reset
  always_ff @(posedge clk) begin
    if (rst_q) begin
      p_reset_idle_r10: assert (irq_o == '0 && status_o == '0 && !msg_valid_o);
    end
  end

  // R1: legacy mode pins channel 0 to line 0 and channel 1 to line 8
  p_legacy0_r1: assert property (@(posedge clk) disable iff (rst)
    (legacy_i && glb_en_i && tmr_en_i[0] && fire_i[0] && !msg_en_i[0]) |=> irq_o[LINE_LEG0]);
  p_legacy1_r1: assert property (@(posedge clk) disable iff (rst)
    (legacy_i && glb_en_i && tmr_en_i[1] && fire_i[1] && !msg_en_i[1]) |=> irq_o[LINE_LEG1]);
  // R8: RTC level reaches its line outside legacy mode
  p_rtc_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (!legacy_i && rtc_i) |=> irq_o[LINE_RTC]);
endmodule

// File: tb/sim_tirq_router.sv
module sim_tirq_router;
  localparam int N = 4;
  localparam int NL = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst, glb, leg, clr_we, rtc;
  logic [N-1:0] ten, lvl, men, fire, clr_data;
  logic [RW-1:0] rt [N];
  logic [63:0] mr [N];
  logic [N*RW-1:0] route_v;
  logic [N*64-1:0] mreg_v;
  logic [NL-1:0] irq;
  logic [N-1:0] st;
  logic mv;
  logic [31:0] ma, md;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      route_v[i*RW +: RW] = rt[i];
      mreg_v[i*64 +: 64]  = mr[i];
    end
  end

  tirq_router #(.N(N), .NLINES(NL), .RW(RW)) u0 (
    .clk(clk), .rst(rst), .glb_en_i(glb), .legacy_i(leg), .tmr_en_i(ten),
    .level_i(lvl), .msg_en_i(men), .route_i(route_v), .msg_reg_i(mreg_v),
    .fire_i(fire), .clr_we_i(clr_we), .clr_data_i(clr_data), .rtc_i(rtc),
    .irq_o(irq), .status_o(st), .msg_valid_o(mv), .msg_addr_o(ma), .msg_data_o(md)
  );

  int checks = 0, errors = 0, cycles = 0;
  bit done = 0;

  function automatic logic [RW-1:0] eff_line(logic lg, int idx, logic [RW-1:0] r);
    if (lg && idx == 0) return 5'd0;
    if (lg && idx == 1) return 5'd8;
    return r;
  endfunction

  // reference model, updated at each rising edge from the driven inputs
  logic [N-1:0] e_st, e_pend, e_mq;
  logic [NL-1:0] e_irq;
  logic e_mv;
  logic [31:0] e_ma, e_md;

  function automatic logic [N-1:0] live_of();
    return fire & ten & {N{glb}};
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      e_st = '0; e_pend = '0; e_mq = '0; e_irq = '0; e_mv = 0; e_ma = '0; e_md = '0;
    end else begin
      logic [N-1:0] lv, ns, mf, ef;
      logic [NL-1:0] nl;
      bit got;
      lv = live_of();
      nl = '0;
      for (int i = 0; i < N; i++) begin
        logic clr;
        clr = (clr_we && clr_data[i]) || !ten[i] || !glb || (men[i] && !e_mq[i]);
        ns[i] = (lv[i] && lvl[i] && !men[i]) || (e_st[i] && !clr);
        ef[i] = lv[i] && !lvl[i] && !men[i];
        mf[i] = lv[i] && men[i];
        if ((ns[i] && !men[i]) || ef[i]) nl[eff_line(leg, i, rt[i])] = 1'b1;
      end
      if (!leg && rtc) nl[8] = 1'b1;
      got = 0;
      for (int i = 0; i < N; i++) begin
        if (e_pend[i] && !got) begin
          got = 1; e_ma = mr[i][63:32]; e_md = mr[i][31:0]; e_pend[i] = 1'b0;
        end
      end
      e_mv = got;
      e_pend = e_pend | mf;
      e_st = ns; e_irq = nl; e_mq = men;
    end
  end

  task automatic chk(string tag, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic step(string tag);
    @(negedge clk);
    cycles++;
    chk(tag, "status", 64'(st), 64'(e_st));
    chk(tag, "irq", 64'(irq), 64'(e_irq));
    chk(tag, "msg_valid", 64'(mv), 64'(e_mv));
    if (e_mv) begin
      chk(tag, "msg_addr", 64'(ma), 64'(e_ma));
      chk(tag, "msg_data", 64'(md), 64'(e_md));
    end
    fire = '0; clr_we = 0; clr_data = '0;
  endtask

  task automatic run(string tag, int n);
    for (int k = 0; k < n; k++) step(tag);
  endtask

  task automatic finish_up();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #4000000;
    errors++;
    $display("FAIL watchdog: actual running expected finished");
    finish_up();
  end

  initial begin
    void'($urandom(32'd20240));
    rst = 1; glb = 0; leg = 0; clr_we = 0; rtc = 0;
    ten = '0; lvl = '0; men = '0; fire = '0; clr_data = '0;
    for (int i = 0; i < N; i++) begin
      rt[i] = 5'(i + 2);
      mr[i] = {32'hA000_0000 + 32'(i), 32'h0000_D000 + 32'(i)};
    end
    run("R10", 3);
    chk("R10", "irq after reset", 64'(irq), 64'd0);
    chk("R10", "status after reset", 64'(st), 64'd0);
    rst = 0; glb = 1; ten = '1; lvl = '1;
    run("R10", 1);

    // R1 legacy routing, then route fields
    leg = 1; fire = 4'b0011; step("R1");
    chk("R1", "lines 0 and 8", 64'(irq), 64'h101);
    clr_we = 1; clr_data = 4'b0011; step("R1");
    leg = 0; fire = 4'b0011; step("R1");
    chk("R1", "route fields 2 and 3", 64'(irq), 64'h00C);
    clr_we = 1; clr_data = '1; step("R1");

    // R2 edge pulse lasts one cycle
    lvl = 4'b1011; fire = 4'b0100; step("R2");
    chk("R2", "edge pulse line 4", 64'(irq), 64'h010);
    step("R2");
    chk("R2", "pulse gone", 64'(irq), 64'h0);
    lvl = '1;

    // R9 shared line
    rt[0] = 5'd3; rt[1] = 5'd3; fire = 4'b0011; step("R9");
    clr_we = 1; clr_data = 4'b0001; step("R9");
    chk("R9", "line held by other channel", 64'(irq[3]), 64'd1);
    clr_we = 1; clr_data = 4'b0010; step("R9");
    chk("R9", "line released", 64'(irq[3]), 64'd0);

    // R4 write-one-to-clear
    fire = 4'b0100; step("R4");
    clr_we = 1; clr_data = 4'b0000; step("R4");
    chk("R4", "zero write keeps bit", 64'(st[2]), 64'd1);
    fire = 4'b0100; clr_we = 1; clr_data = 4'b0100; step("R4");
    chk("R4", "fire wins over clear", 64'(st[2]), 64'd1);
    clr_we = 1; clr_data = 4'b0100; step("R4");
    chk("R4", "one write clears", 64'(st[2]), 64'd0);

    // R3 enables
    fire = 4'b1100; step("R3");
    ten[3] = 0; step("R3");
    chk("R3", "channel disable clears", 64'(st[3]), 64'd0);
    glb = 0; fire = 4'b0011; step("R3");
    chk("R3", "global disable clears all", 64'(st), 64'd0);
    glb = 1; ten = '1; step("R3");

    // R7 message enable rising clears status
    fire = 4'b0010; step("R7");
    men[1] = 1; step("R7");
    chk("R7", "status cleared", 64'(st[1]), 64'd0);
    men = '0; step("R7");

    // R5 single message write
    men[3] = 1; fire = 4'b1000; step("R5");
    step("R5");
    chk("R5", "message valid", 64'(mv), 64'd1);
    chk("R5", "message address", 64'(ma), 64'hA000_0003);
    step("R5");
    chk("R5", "one write only", 64'(mv), 64'd0);

    // R6 ordering and merge
    men = '1; fire = 4'b1111; step("R6");
    fire = 4'b1000; step("R6");
    chk("R6", "first is channel 0", 64'(md), 64'h0000_D000);
    run("R6", 3);
    chk("R6", "last is channel 3", 64'(md), 64'h0000_D003);
    step("R6");
    chk("R6", "merged refire", 64'(mv), 64'd0);
    men = '0; step("R6");

    // R8 RTC pass-through and legacy gating
    rtc = 1; step("R8");
    chk("R8", "rtc on line 8", 64'(irq[8]), 64'd1);
    leg = 1; step("R8");
    chk("R8", "legacy mutes rtc", 64'(irq[8]), 64'd0);
    leg = 0; step("R8");
    chk("R8", "restored level", 64'(irq[8]), 64'd1);
    rtc = 0; step("R8");

    // random mix
    for (int k = 0; k < 2000; k++) begin
      glb = ($urandom % 16) != 0;
      ten = 4'($urandom) | 4'($urandom);
      lvl = 4'($urandom) | 4'($urandom);
      if ($urandom % 8 == 0) men = 4'($urandom) & 4'($urandom);
      if ($urandom % 16 == 0) leg = ~leg;
      rtc = ($urandom % 4) == 0 ? ~rtc : rtc;
      fire = 4'($urandom);
      clr_we = $urandom % 2;
      clr_data = 4'($urandom);
      for (int i = 0; i < N; i++) begin
        if ($urandom % 8 == 0) begin
          case ($urandom % 4)
            0: rt[i] = 5'd0;
            1: rt[i] = 5'd3;
            2: rt[i] = 5'd8;
            default: rt[i] = 5'd31;
          endcase
        end
        if ($urandom % 8 == 0) mr[i] = {$urandom, $urandom};
      end
      if ($urandom % 500 == 0) rst = 1;
      step("R9");
      rst = 0;
    end
    finish_up();
  end
endmodule